// File: doc/BRIEF.md
# Clock Frequency Accuracy Monitor

This block judges whether a target clock runs at the expected rate. It uses the system clock as the reference. It opens a measurement window of a programmed number of reference cycles. During the window a counter clocked by the target clock counts target cycles. When the window closes, the count is sent back to the system domain. There it is compared against an inclusive band set by a lower and an upper limit, and the block reports completion and, when the count falls outside the band, a range error.

Software sets the limits, the window length and the run mode through a small word-addressed register port, then starts a run. In single mode exactly one window is measured. In continuous mode a new window opens in the same cycle a result is taken, until software asks the block to stop. Two interrupt lines follow the sticky completion and error flags.

Top module: `clk_acc_mon`

## Requirements
- R1: The window lasts WIN_BASE times 1, 4, 8 or 32 reference cycles, selected by control word (address 0) bits [3:2] = 0, 1, 2, 3. The reported count is within 2 of the window time divided by the target period.
- R2: At the end of each window the target-domain count is returned to the system domain. It is readable in bits [CNT_W-1:0] of address 3 and stays valid until the next result.
- R3: The target counter stops at 2^CNT_W-1 instead of wrapping. A result equal to that value always flags a range error, whatever the limits are.
- R4: The range error is set when the count is below the lower limit (address 1 bits [15:0]) or above the upper limit (address 1 bits [31:16]). Both limits are inclusive.
- R5: Status bit 0 (address 2) is set at every window end, and irq_done equals it.
- R6: Status bit 1 is set at a window end whose verdict is out of range, and irq_range equals it.
- R7: Both status bits are sticky. Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R8: While a run is active (control bit 0 reads 1), writes to the limits, to the mode bit (control bit 1) and to the divider field are ignored.
- R9: With control bit 1 = 0, writing control bit 0 = 1 measures one window, after which the block goes idle and starts no further window.
- R10: With control bit 1 = 1, windows repeat back to back. Writing the control word with bit 0 = 0 during a run ends the run once the current window has reported.
- R11: After reset the control word, status and count read 0, the limits read lower 0 and upper 2^CNT_W-1, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_clk | input | 1 | Clock under measurement |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq_done | output | 1 | Measurement-complete request |
| irq_range | output | 1 | Count-out-of-band request |

## Verification
The bench drives the target clock at many periods and window lengths. It checks each verdict against limits placed a few counts around the nominal value, so off-by-one errors at the inclusive band edges show up as wrong error flags. A fast target clock on the longest window drives the counter into saturation; a counter that wrapped would report a small value and could pass. Writes to configuration during a continuous run must leave the readback unchanged, and a stop request must end the run; a design that latched those writes or ignored the stop would show altered limits or a run that never goes idle. In single mode the completion flag is cleared and must not return, which catches a block that keeps re-arming.

// File: rtl/cam_pkg.sv
`timescale 1ns/1ps
package cam_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_WAIT = 2'd2
  } win_st_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_LIMIT = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;
  localparam logic [1:0] ADDR_COUNT = 2'd3;

  // divider code to left shift: 1, 4, 8, 32
  function automatic int unsigned div_shift(logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 2;
      2'd2:    return 3;
      default: return 5;
    endcase
  endfunction

  function automatic int unsigned win_cycles(int unsigned base, logic [1:0] sel);
    return base << div_shift(sel);
  endfunction

  // verdict: saturated or outside the inclusive band
  function automatic logic out_of_band(logic [15:0] c, logic [15:0] lo,
                                       logic [15:0] hi, logic [15:0] top);
    return (c == top) || (c < lo) || (c > hi);
  endfunction

endpackage

// File: rtl/cam_sync.sv
`timescale 1ns/1ps
module cam_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cam_tgt_count.sv
`timescale 1ns/1ps
module cam_tgt_count #(
  parameter int CNT_W = 16
) (
  input  logic             tgt_clk,
  input  logic             tgt_rst_n,
  input  logic             win_a,
  input  logic             ack_a,
  output logic [CNT_W-1:0] hold_o,
  output logic             req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             win_s, win_d, ack_s;
  logic [CNT_W-1:0] cnt_q;

  cam_sync #(.W(1)) u_win_sync (.clk(tgt_clk), .rst_n(tgt_rst_n), .d(win_a), .q(win_s));
  cam_sync #(.W(1)) u_ack_sync (.clk(tgt_clk), .rst_n(tgt_rst_n), .d(ack_a), .q(ack_s));

  // named events of the target domain
  logic rise_w, fall_w, run_w, busy_w;
  assign rise_w = win_s & ~win_d;
  assign fall_w = ~win_s & win_d;
  assign run_w  = win_s & win_d;
  assign busy_w = req_o ^ ack_s;

  function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge tgt_clk or negedge tgt_rst_n) begin
    if (!tgt_rst_n) begin
      win_d  <= 1'b0;
      cnt_q  <= '0;
      hold_o <= '0;
      req_o  <= 1'b0;
    end else begin
      win_d <= win_s;
      if (rise_w)     cnt_q <= CNT_W'(1);
      else if (run_w) cnt_q <= sat_inc(cnt_q);
      if (fall_w) begin
        hold_o <= cnt_q;
        req_o  <= ~req_o;
      end
    end
  end

  p_cnt_saturates_r3: assert property (@(posedge tgt_clk) disable iff (!tgt_rst_n)
    (run_w && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  p_capture_when_acked_r2: assert property (@(posedge tgt_clk) disable iff (!tgt_rst_n)
    fall_w |-> !busy_w);

  p_hold_changes_on_close_r2: assert property (@(posedge tgt_clk) disable iff (!tgt_rst_n)
    !fall_w |=> $stable(hold_o));
endmodule

// File: rtl/cam_window_ctrl.sv
`timescale 1ns/1ps
module cam_window_ctrl
  import cam_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WIN_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             cont_i,
  input  logic [1:0]       div_sel_i,
  input  logic             req_a,
  input  logic [CNT_W-1:0] cnt_a,
  output logic             win_o,
  output logic             ack_o,
  output logic             res_vld_o,
  output logic [CNT_W-1:0] res_cnt_o,
  output logic             busy_o
);
  localparam int DIV_W = $clog2(WIN_BASE * 32);

  win_st_e          st_q;
  logic [DIV_W-1:0] div_q;
  logic             keep_q, req_s, req_d;

  cam_sync #(.W(1)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(req_a), .q(req_s));

  logic req_edge_w, again_w;
  assign req_edge_w = req_s ^ req_d;
  assign again_w    = cont_i && keep_q && !stop_i;
  assign busy_o     = (st_q != ST_IDLE);

  function automatic logic [DIV_W-1:0] load_value(logic [1:0] sel);
    return DIV_W'(win_cycles(WIN_BASE, sel) - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      div_q     <= '0;
      keep_q    <= 1'b0;
      req_d     <= 1'b0;
      win_o     <= 1'b0;
      ack_o     <= 1'b0;
      res_vld_o <= 1'b0;
      res_cnt_o <= '0;
    end else begin
      req_d     <= req_s;
      res_vld_o <= 1'b0;
      if (stop_i) keep_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_OPEN;
          win_o  <= 1'b1;
          div_q  <= load_value(div_sel_i);
          keep_q <= !stop_i;
        end
        ST_OPEN: if (div_q == '0) begin
          win_o <= 1'b0;
          st_q  <= ST_WAIT;
        end else begin
          div_q <= div_q - 1'b1;
        end
        ST_WAIT: if (req_edge_w) begin
          ack_o     <= ~ack_o;
          res_cnt_o <= cnt_a;
          res_vld_o <= 1'b1;
          if (again_w) begin
            st_q  <= ST_OPEN;
            win_o <= 1'b1;
            div_q <= load_value(div_sel_i);
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_wait_window_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !win_o);

  p_single_goes_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && !cont_i) |-> !busy_o);

  p_cont_reopens_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && cont_i && keep_q) |-> win_o);
endmodule

// File: rtl/cam_regs.sv
`timescale 1ns/1ps
module cam_regs
  import cam_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             busy_i,
  input  logic             res_vld_i,
  input  logic [CNT_W-1:0] res_cnt_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             cont_o,
  output logic [1:0]       div_sel_o,
  output logic             irq_done_o,
  output logic             irq_range_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] lo_q, hi_q, cnt_q;
  logic             done_q, err_q;

  logic busy_w, wr_ctrl_w, wr_lim_w, wr_stat_w, verdict_w;
  assign busy_w    = busy_i | start_o;
  assign wr_ctrl_w = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_lim_w  = bus_wr && (bus_addr == ADDR_LIMIT);
  assign wr_stat_w = bus_wr && (bus_addr == ADDR_STAT);
  assign stop_o    = wr_ctrl_w && busy_w && !bus_wdata[0];
  assign verdict_w = out_of_band(16'(res_cnt_i), 16'(lo_q), 16'(hi_q), 16'(CNT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_q      <= CNT_MAX;
      cnt_q     <= '0;
      cont_o    <= 1'b0;
      div_sel_o <= 2'd0;
      start_o   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (wr_ctrl_w && !busy_w) begin
        cont_o    <= bus_wdata[1];
        div_sel_o <= bus_wdata[3:2];
        start_o   <= bus_wdata[0];
      end
      if (wr_lim_w && !busy_w) begin
        lo_q <= bus_wdata[CNT_W-1:0];
        hi_q <= bus_wdata[16 +: CNT_W];
      end
      if (res_vld_i) cnt_q <= res_cnt_i;
      done_q <= res_vld_i | (done_q & ~(wr_stat_w & bus_wdata[0]));
      err_q  <= (res_vld_i & verdict_w) | (err_q & ~(wr_stat_w & bus_wdata[1]));
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:  bus_rdata = {28'd0, div_sel_o, cont_o, busy_w};
      ADDR_LIMIT: bus_rdata = {16'(hi_q), 16'(lo_q)};
      ADDR_STAT:  bus_rdata = {30'd0, err_q, done_q};
      default:    bus_rdata = {16'd0, 16'(cnt_q)};
    endcase
  end

  assign irq_done_o  = done_q;
  assign irq_range_o = err_q;

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> ($stable(lo_q) && $stable(hi_q) && $stable(div_sel_o) && $stable(cont_o)));

  p_done_on_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_i |=> done_q);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !(wr_stat_w && bus_wdata[0])) |=> done_q);

  p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> done_q);
endmodule

// File: rtl/clk_acc_mon.sv
`timescale 1ns/1ps
module clk_acc_mon #(
  parameter int CNT_W    = 16,
  parameter int WIN_BASE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tgt_clk,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_done,
  output logic        irq_range
);
  logic             tgt_rst_n;
  logic             start_w, stop_w, cont_w, busy_w;
  logic [1:0]       div_w;
  logic             win_w, ack_w, req_w, res_vld_w;
  logic [CNT_W-1:0] hold_w, res_cnt_w;

  cam_sync #(.W(1)) u_tgt_rst (
    .clk(tgt_clk), .rst_n(rst_n), .d(1'b1), .q(tgt_rst_n));

  cam_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy_w),
    .res_vld_i(res_vld_w), .res_cnt_i(res_cnt_w), .start_o(start_w),
    .stop_o(stop_w), .cont_o(cont_w), .div_sel_o(div_w),
    .irq_done_o(irq_done), .irq_range_o(irq_range));

  cam_window_ctrl #(.CNT_W(CNT_W), .WIN_BASE(WIN_BASE)) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .stop_i(stop_w),
    .cont_i(cont_w), .div_sel_i(div_w), .req_a(req_w), .cnt_a(hold_w),
    .win_o(win_w), .ack_o(ack_w), .res_vld_o(res_vld_w),
    .res_cnt_o(res_cnt_w), .busy_o(busy_w));

  cam_tgt_count #(.CNT_W(CNT_W)) u_cnt (
    .tgt_clk(tgt_clk), .tgt_rst_n(tgt_rst_n), .win_a(win_w), .ack_a(ack_w),
    .hold_o(hold_w), .req_o(req_w));
endmodule

// File: tb/clk_acc_mon_tb_top.sv
`timescale 1ns/1ps
module clk_acc_mon_tb_top;
  localparam int CNT_W    = 10;
  localparam int WIN_BASE = 16;
  localparam int MAXC     = (1 << CNT_W) - 1;
  localparam real TCLK    = 20.0;

  logic        clk = 1'b0, tgt_clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_done, irq_range;
  real         tgt_half = 5.0;
  int          tests = 0, fails = 0;
  logic [31:0] rv;

  clk_acc_mon #(.CNT_W(CNT_W), .WIN_BASE(WIN_BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tgt_clk(tgt_clk), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_done(irq_done), .irq_range(irq_range));

  always #(TCLK / 2.0) clk = ~clk;
  initial forever #(tgt_half) tgt_clk = ~tgt_clk;

  function automatic int mult_of(int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 32;
    endcase
  endfunction

  function automatic real window_ns(int sel);
    return WIN_BASE * mult_of(sel) * TCLK;
  endfunction

  function automatic bit expect_err(int c, int lo, int hi);
    return (c == MAXC) || (c < lo) || (c > hi);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq_done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(real tper, int sel, int lo, int hi);
    bit ok;
    logic [31:0] st, cn, ct;
    real nom, diff;
    tgt_half = tper / 2.0;
    repeat (4) @(negedge clk);
    wr(2'd1, (32'(hi) << 16) | 32'(lo));
    wr(2'd2, 32'd3);
    wr(2'd0, (32'(sel) << 2) | 32'd1);
    wait_done(ok);
    check(ok, "R5 completion seen", int'(ok), 1);
    rd(2'd3, cn);
    rd(2'd2, st);
    nom = window_ns(sel) / tper;
    if (nom > MAXC + 2) begin
      check(cn == MAXC, "R3 saturated count", int'(cn), MAXC);
    end else begin
      diff = real'(int'(cn)) - nom;
      check(diff <= 2.0 && diff >= -2.0, "R1 count vs window", int'(cn), $rtoi(nom));
    end
    check(st[0] == 1'b1, "R5 done flag", int'(st[0]), 1);
    check(st[1] == expect_err(int'(cn), lo, hi), "R4 verdict",
          int'(st[1]), int'(expect_err(int'(cn), lo, hi)));
    check(irq_range == st[1], "R6 irq_range mirrors flag", int'(irq_range), int'(st[1]));
    rd(2'd0, ct);
    check(ct[0] == 1'b0, "R9 idle after single", int'(ct[0]), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ok;
    int seed_sink;
    seed_sink = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(2'd0, rv); check(rv == 32'd0, "R11 ctrl reset", int'(rv), 0);
    rd(2'd1, rv); check(rv == (32'(MAXC) << 16), "R11 limit reset", int'(rv), MAXC << 16);
    rd(2'd2, rv); check(rv == 32'd0, "R11 status reset", int'(rv), 0);
    rd(2'd3, rv); check(rv == 32'd0, "R11 count reset", int'(rv), 0);
    check(!irq_done && !irq_range, "R11 irq low", int'(irq_done), 0);

    // directed: each window length, wide band
    for (int s = 0; s < 4; s++) measure(23.0, s, 0, MAXC - 1);
    // R3: saturation flags error even with widest band
    measure(5.0, 3, 0, MAXC);
    // R4: band far above and below the count
    measure(20.0, 1, 200, 300);
    measure(20.0, 1, 0, 10);

    // constrained random trials, band near nominal
    for (int t = 0; t < 14; t++) begin
      int sel, per, nom, lo, hi;
      sel = int'($urandom % 4);
      per = 11 + int'($urandom % 30);
      nom = $rtoi(window_ns(sel) / real'(per));
      lo  = nom - 4 + int'($urandom % 7);
      hi  = lo + int'($urandom % 5);
      if (lo < 0) lo = 0;
      if (hi > MAXC - 1) hi = MAXC - 1;
      measure(real'(per), sel, lo, hi);
    end

    // R7: write-one-to-clear, per bit
    measure(17.0, 0, 0, 0);
    wr(2'd2, 32'd2); rd(2'd2, rv);
    check(rv == 32'd1, "R7 clear err only", int'(rv), 1);
    wr(2'd2, 32'd0); rd(2'd2, rv);
    check(rv == 32'd1, "R7 zero write no effect", int'(rv), 1);
    wr(2'd2, 32'd1); rd(2'd2, rv);
    check(rv == 32'd0, "R7 clear done", int'(rv), 0);
    check(!irq_done && !irq_range, "R7 irqs dropped", int'(irq_done), 0);

    // R9: single mode does not start another window
    repeat (1500) @(negedge clk);
    rd(2'd2, rv);
    check(rv[0] == 1'b0, "R9 no second window", int'(rv[0]), 0);

    // R10 continuous run, R8 ignored writes
    tgt_half = 5.0;
    wr(2'd1, 32'h03FF_0000);
    wr(2'd2, 32'd3);
    wr(2'd0, 32'd3);
    wait_done(ok);
    check(ok, "R10 first window", int'(ok), 1);
    wr(2'd2, 32'd1);
    wait_done(ok);
    check(ok, "R10 repeat window", int'(ok), 1);
    rd(2'd0, rv);
    check(rv[0] == 1'b1, "R10 still busy", int'(rv[0]), 1);
    wr(2'd1, 32'h0005_0004);
    rd(2'd1, rv);
    check(rv == 32'h03FF_0000, "R8 limits ignored", int'(rv), 32'h03FF_0000);
    wr(2'd0, 32'd13);
    rd(2'd0, rv);
    check(rv == 32'd3, "R8 ctrl ignored", int'(rv), 3);
    wr(2'd0, 32'd0);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd0, rv);
      if (rv[0] == 1'b0) begin ok = 1'b1; break; end
    end
    check(ok, "R10 stop ends run", int'(ok), 1);
    rd(2'd0, rv);
    check(rv == 32'd2, "R8 mode kept through stop", int'(rv), 2);
    rd(2'd3, rv);
    check(rv > 0 && rv < MAXC, "R2 count readable", int'(rv), 32);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule